// File: doc/BRIEF.md
# Register-Pointer Serial Slave

This block is a two-wire serial bus slave (I2C protocol, 7-bit addressing) that lets an external bus master read and write a small register file through an 8-bit register pointer. The system clock oversamples both bus lines. The block recognises START, repeated START and STOP conditions. It answers only to the address 1101011, and the direction bit that follows the address selects a read or a write.

In a write transfer, the byte after the address sets the pointer. Each later byte is stored at the register the pointer selects, and the pointer then advances by one. In a read transfer, the block sends bytes starting at the current pointer and advances the pointer after each byte. A read that has no pointer byte therefore continues from wherever the last transfer left off. The data line is open drain: the block only ever pulls it low. The register file sits outside the block, behind a simple address, write-strobe and read-data port.

Top module: `regptr_i2c_slave`

## Requirements
- R1: After reset, the data line is released, no write strobe is active and the pointer is 0x00.
- R2: An address byte whose upper seven bits are 1101011 is acknowledged by pulling the data line low during the ninth clock. Bit 0 of that byte selects the direction: 0 is a write and 1 is a read.
- R3: Any other address gets no acknowledge. The block then causes no register writes and does not drive the data line until the next START or STOP.
- R4: In a write transfer, the first byte after the address is acknowledged and loads the pointer. It causes no register write.
- R5: Each later byte of a write transfer is acknowledged and written to the register at the pointer with exactly one strobe. The pointer then increments by one.
- R6: In a read transfer, bytes are sent MSB first, starting at the current pointer. The pointer increments after each byte, so a read with no pointer byte continues from the pointer the last transfer left.
- R7: An acknowledge from the master after a read byte causes the next byte to be sent. A not-acknowledge makes the block release the data line until the next START or STOP.
- R8: A repeated START at any point ends the current transfer and begins a new address phase. A STOP also ends the transfer. A partly received byte is discarded and never written.
- R9: The pointer wraps from 0xFF to 0x00, in both writes and reads.
- R10: The block changes the level it drives on the data line only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaDriveLow | output | 1 | When 1, the data line is pulled low |
| regAddr | output | 8 | Register pointer, used as the register-file address |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Data to write, valid with regWrEn |
| regRdData | input | 8 | Register-file read data for the address on regAddr |

## Verification
Two functions land on the same clock edge: the write strobe of a data byte and the pointer step that follows it. When the pointer sits at 0xFF, that step also wraps it to 0x00. The bench sets this up with a burst write that starts at 0xFD and crosses the wrap. It judges the result from its own register-file model: the byte for 0xFF must land at 0xFF, the next byte must land at 0x00, and the strobe count must equal the number of data bytes. A read burst that starts at 0xFE then shows the same wrap on the read side, where the pointer step and the next byte fetch sit one bus-clock edge apart.

// File: rtl/regptr_i2c_pkg.sv
package regptr_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_IGNORE
  } ctlState_t;

  typedef enum logic [1:0] {
    RX_ADDR, RX_PTR, RX_DATA
  } rxKind_t;

  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic loadPtr;
    logic incPtr;
    logic wrStrobe;
  } dpCtl_t;
endpackage

// File: rtl/regptr_i2c_dp.sv
module regptr_i2c_dp
  import regptr_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] rdData,
  output logic              sclLevel,
  output logic              sdaLevel,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startSeen,
  output logic              stopSeen,
  output logic [BYTE_W-1:0] shReg,
  output logic              txBit,
  output logic [BYTE_W-1:0] ptr
);
  localparam int LINES = 2;
  localparam int SCL_IDX = 0;
  localparam int SDA_IDX = 1;

  logic [LINES-1:0] rawIn;
  logic [LINES-1:0] lineLvl;
  logic [LINES-1:0] linePrev;

  assign rawIn = {sdaIn, sclIn};

  // one synchronizer plus one history flop for each bus line
  for (genvar g = 0; g < LINES; g++) begin : gSync
    logic [SYNC_STAGES-1:0] pipe;
    logic                   prev;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pipe <= '1;
        prev <= 1'b1;
      end else begin
        pipe <= {pipe[SYNC_STAGES-2:0], rawIn[g]};
        prev <= pipe[SYNC_STAGES-1];
      end
    end
    assign lineLvl[g]  = pipe[SYNC_STAGES-1];
    assign linePrev[g] = prev;
  end

  assign sclLevel  = lineLvl[SCL_IDX];
  assign sdaLevel  = lineLvl[SDA_IDX];
  assign sclRise   = lineLvl[SCL_IDX] & ~linePrev[SCL_IDX];
  assign sclFall   = ~lineLvl[SCL_IDX] & linePrev[SCL_IDX];
  assign startSeen = lineLvl[SCL_IDX] & linePrev[SCL_IDX] & linePrev[SDA_IDX] & ~lineLvl[SDA_IDX];
  assign stopSeen  = lineLvl[SCL_IDX] & linePrev[SCL_IDX] & ~linePrev[SDA_IDX] & lineLvl[SDA_IDX];

  // shared shift register: receive path fills from the bit line, transmit path empties from MSB
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (ctl.loadTx) begin
      shReg <= rdData;
    end else if (ctl.shiftTx) begin
      shReg <= {shReg[BYTE_W-2:0], 1'b1};
    end else if (ctl.shiftIn) begin
      shReg <= {shReg[BYTE_W-2:0], sdaLevel};
    end
  end

  assign txBit = shReg[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (ctl.loadPtr) begin
      ptr <= shReg;
    end else if (ctl.incPtr) begin
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/regptr_i2c_ctl.sv
module regptr_i2c_ctl
  import regptr_i2c_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'b1101011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              sdaLevel,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  output dpCtl_t            ctl,
  output logic              sdaDriveLow
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  ctlState_t         state;
  rxKind_t           kind;
  logic [CNT_W-1:0]  bitCnt;
  logic              full;
  logic              readMode;
  logic              masterAck;

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_RX: begin
        ctl.shiftIn = sclRise & ~full;
        if (sclFall && full) begin
          ctl.loadPtr  = (kind == RX_PTR);
          ctl.wrStrobe = (kind == RX_DATA);
          ctl.incPtr   = (kind == RX_DATA);
        end
      end
      ST_ACK:   ctl.loadTx = sclFall & readMode;
      ST_TX: begin
        if (sclFall) begin
          ctl.incPtr  = (bitCnt == LAST_BIT);
          ctl.shiftTx = (bitCnt != LAST_BIT);
        end
      end
      ST_TXACK: ctl.loadTx = sclFall & masterAck;
      default: ;
    endcase
  end

  assign sdaDriveLow = (state == ST_ACK) || ((state == ST_TX) && !txBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= RX_ADDR;
      bitCnt    <= '0;
      full      <= 1'b0;
      readMode  <= 1'b0;
      masterAck <= 1'b0;
    end else if (startSeen) begin
      state  <= ST_RX;
      kind   <= RX_ADDR;
      bitCnt <= '0;
      full   <= 1'b0;
    end else if (stopSeen) begin
      state <= ST_IDLE;
      full  <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise && !full) begin
            if (bitCnt == LAST_BIT) full <= 1'b1;
            else bitCnt <= bitCnt + 1'b1;
          end
          if (sclFall && full) begin
            full   <= 1'b0;
            bitCnt <= '0;
            if (kind == RX_ADDR) begin
              if (rxByte[BYTE_W-1:1] == SLAVE_ADDR) begin
                state    <= ST_ACK;
                readMode <= rxByte[0];
                kind     <= RX_PTR;
              end else begin
                state <= ST_IGNORE;
              end
            end else begin
              state    <= ST_ACK;
              readMode <= 1'b0;
              kind     <= RX_DATA;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            state  <= readMode ? ST_TX : ST_RX;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == LAST_BIT) state <= ST_TXACK;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_TXACK: begin
          if (sclRise) masterAck <= ~sdaLevel;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= masterAck ? ST_TX : ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/regptr_i2c_slave.sv
module regptr_i2c_slave
  import regptr_i2c_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'b1101011,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  output logic [BYTE_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] regRdData
);
  dpCtl_t            ctl;
  logic              sclLevel;
  logic              sdaLevel;
  logic              sclRise;
  logic              sclFall;
  logic              startSeen;
  logic              stopSeen;
  logic [BYTE_W-1:0] shReg;
  logic              txBit;

  regptr_i2c_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctl(ctl), .rdData(regRdData),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel),
    .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen),
    .shReg(shReg), .txBit(txBit), .ptr(regAddr)
  );

  regptr_i2c_ctl #(.SLAVE_ADDR(SLAVE_ADDR)) u_ctl (
    .clk(clk), .rstN(rstN),
    .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen),
    .sdaLevel(sdaLevel), .rxByte(shReg), .txBit(txBit),
    .ctl(ctl), .sdaDriveLow(sdaDriveLow)
  );

  assign regWrEn   = ctl.wrStrobe;
  assign regWrData = shReg;
endmodule

// File: rtl/regptr_i2c_chk.sv
module regptr_i2c_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sdaDriveLow,
  input logic       regWrEn,
  input logic [7:0] regAddr,
  input logic       sclLevel,
  input logic       startSeen
);
  a_r10_drive_changes_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclLevel);

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  a_r5_ptr_step_after_write: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWrEn) |-> regAddr == 8'($past(regAddr) + 8'd1));

  a_r9_ptr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWrEn) && $past(regAddr) == 8'hFF) |-> regAddr == 8'h00);

  a_r5_write_while_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !sclLevel);

  a_r8_start_leaves_line_free: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> !sdaDriveLow);
endmodule

bind regptr_i2c_slave regptr_i2c_chk u_chk (
  .clk(clk), .rstN(rstN), .sdaDriveLow(sdaDriveLow), .regWrEn(regWrEn),
  .regAddr(regAddr), .sclLevel(sclLevel), .startSeen(startSeen)
);

// File: tb/regptr_i2c_slave_test.sv
module regptr_i2c_slave_test;
  localparam int Q = 5;
  localparam logic [6:0] MY_ADDR = 7'b1101011;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaBus;
  logic       sdaDriveLow;
  logic [7:0] regAddr;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;

  logic [7:0] mem [256];
  logic [7:0] exp [256];
  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  int edgeViol = 0;
  logic prevDrive = 1'b0;

  always #2.5 clk = ~clk;

  assign sdaBus    = sdaM & ~sdaDriveLow;
  assign regRdData = mem[regAddr];

  regptr_i2c_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (regWrEn) begin
      mem[regAddr] <= regWrData;
      wrCount <= wrCount + 1;
    end
  end

  // R10 monitor: drive level must not change while the raw bus clock is high
  always @(negedge clk) begin
    if (rstN && sdaDriveLow != prevDrive && sclM) edgeViol <= edgeViol + 1;
    prevDrive <= sdaDriveLow;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b1; tick(Q);
  endtask

  task automatic bitCycle(input logic b, output logic r);
    sdaM = b;    tick(Q);
    sclM = 1'b1; tick(Q);
    r = sdaBus;  tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bitCycle(v[i], r);
    bitCycle(1'b1, r);
    ack = ~r;
  endtask

  task automatic getByte(input logic giveAck, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, r);
      v[i] = r;
    end
    bitCycle(~giveAck, r);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic ack;
    logic [7:0] v;
    int wr0;
    for (int i = 0; i < 256; i++) exp[i] = 8'(i) ^ 8'hA5;
    tick(4);
    chk("R1 drive in reset", 32'(sdaDriveLow), 0);
    rstN = 1'b1;
    tick(4);
    chk("R1 drive after reset", 32'(sdaDriveLow), 0);
    chk("R1 strobe after reset", 32'(regWrEn), 0);
    chk("R1 pointer after reset", 32'(regAddr), 0);

    // read straight after reset: starts at pointer 0
    busStart();
    sendByte({MY_ADDR, 1'b1}, ack);
    chk("R2 read address ack", 32'(ack), 1);
    getByte(1'b1, v); chk("R6 first read byte", 32'(v), 32'(exp[0]));
    getByte(1'b0, v); chk("R6 second read byte", 32'(v), 32'(exp[1]));
    busStop();

    // exhaustive address sweep, write direction, pointer 0x40 then one data byte
    for (int a = 0; a < 128; a++) begin
      logic hit;
      hit = (7'(a) == MY_ADDR);
      busStart();
      sendByte({7'(a), 1'b0}, ack);
      chk(hit ? "R2 address ack" : "R3 foreign address nack", 32'(ack), 32'(hit));
      sendByte(8'h40, ack);
      chk(hit ? "R4 pointer ack" : "R3 ignored pointer byte", 32'(ack), 32'(hit));
      sendByte(8'(a) ^ 8'h5A, ack);
      chk(hit ? "R5 data ack" : "R3 ignored data byte", 32'(ack), 32'(hit));
      if (hit) exp[8'h40] = 8'(a) ^ 8'h5A;
      busStop();
    end
    chk("R3 one write across sweep", 32'(wrCount), 1);
    chk("R5 swept data stored", 32'(mem[8'h40]), 32'(exp[8'h40]));

    // foreign read address: line never driven
    busStart();
    sendByte({7'b1101010, 1'b1}, ack);
    chk("R3 foreign read nack", 32'(ack), 0);
    getByte(1'b1, v);
    chk("R3 foreign read line idle", 32'(v), 32'hFF);
    busStop();

    // burst write across the wrap
    wr0 = wrCount;
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack); chk("R2 write address ack", 32'(ack), 1);
    sendByte(8'hFD, ack);           chk("R4 pointer byte ack", 32'(ack), 1);
    for (int k = 0; k < 5; k++) begin
      logic [7:0] d;
      d = 8'(8'h11 * (k + 1));
      sendByte(d, ack);
      chk("R5 burst data ack", 32'(ack), 1);
      exp[8'(8'hFD + k)] = d;
    end
    busStop();
    chk("R5 burst strobe count", 32'(wrCount - wr0), 5);
    for (int k = 0; k < 5; k++)
      chk("R9 burst write across wrap", 32'(mem[8'(8'hFD + k)]), 32'(exp[8'(8'hFD + k)]));

    // read with no pointer byte resumes at 0x02
    busStart();
    sendByte({MY_ADDR, 1'b1}, ack);
    getByte(1'b1, v); chk("R6 resume byte 0", 32'(v), 32'(exp[2]));
    getByte(1'b1, v); chk("R6 resume byte 1", 32'(v), 32'(exp[3]));
    getByte(1'b0, v); chk("R7 byte before nack", 32'(v), 32'(exp[4]));
    getByte(1'b1, v); chk("R7 line released after nack", 32'(v), 32'hFF);
    busStop();

    // pointer-only write then read across the wrap
    wr0 = wrCount;
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    sendByte(8'hFE, ack);
    busStop();
    chk("R4 pointer byte writes nothing", 32'(wrCount - wr0), 0);
    chk("R4 register at pointer kept", 32'(mem[8'hFE]), 32'(exp[8'hFE]));
    busStart();
    sendByte({MY_ADDR, 1'b1}, ack);
    getByte(1'b1, v); chk("R9 read at 0xFE", 32'(v), 32'(exp[8'hFE]));
    getByte(1'b1, v); chk("R9 read at 0xFF", 32'(v), 32'(exp[8'hFF]));
    getByte(1'b0, v); chk("R9 read wraps to 0x00", 32'(v), 32'(exp[0]));
    busStop();

    // repeated START from a write straight into a read
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    sendByte(8'h10, ack);
    sendByte(8'h3C, ack);
    exp[8'h10] = 8'h3C;
    busStart();
    sendByte({MY_ADDR, 1'b1}, ack);
    chk("R8 address after repeated START", 32'(ack), 1);
    getByte(1'b0, v);
    chk("R8 read follows write pointer", 32'(v), 32'(exp[8'h11]));
    busStop();
    chk("R8 byte before repeated START", 32'(mem[8'h10]), 32'h3C);

    // STOP in the middle of a data byte
    wr0 = wrCount;
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    sendByte(8'h20, ack);
    for (int k = 0; k < 4; k++) bitCycle(1'b0, ack);
    busStop();
    chk("R8 partial byte not written", 32'(wrCount - wr0), 0);
    chk("R8 register kept after STOP", 32'(mem[8'h20]), 32'(exp[8'h20]));

    chk("R10 drive changes with clock low", 32'(edgeViol), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule